// File: doc/BRIEF.md
# Idle-Driven Multi-Level Sleep Governor

This block decides how deeply a processing block may sleep. It counts consecutive clock cycles in which the block reports no activity and no one asks for a wake-up. As that idle run grows past three programmable thresholds, it steps the power state one level deeper each time. The four states run from fully on to the deepest cut-off. The current state leaves on a 2-bit select bus that feeds the power-switch control.

Any activity or explicit wake request seen in a low-power state sends the select bus straight back to the active code. A wake countdown then starts, and its length is programmed separately for each level being left. A ready flag stays low until that countdown ends. A retention flag tells the system whether the present state keeps register contents. A one-cycle loss pulse marks a wake from the only level that loses them, so that context can be restored.

Top module: `sleep_governor`

## Requirements
- R1: After reset, pwr_sel is 00, ready is 1, retain is 1 and state_lost is 0.
- R2: pwr_sel encodes the state as 00 active, 01 sleep, 10 dream, 11 snore.
- R3: A cycle is idle when activity and wake_req are both 0 and ready is 1. pwr_sel becomes 01 at the clock edge that completes the thr_l1-th consecutive idle cycle, 10 at the thr_l2-th and 11 at the thr_l3-th. It then stays 11 while idle continues, and it never moves more than one level per edge (thresholds set so that 1 <= thr_l1 < thr_l2 < thr_l3).
- R4: If activity or wake_req is 1 at an edge while pwr_sel is not 00 and ready is 1, pwr_sel is 00 and ready is 0 after that edge.
- R5: After a wake starts, ready stays 0 for exactly the wake latency of the state left (wake_lat_l1 for sleep, wake_lat_l2 for dream, wake_lat_l3 for snore), then returns to 1. A latency of 0 acts as 1.
- R6: retain is 1 in active, sleep and dream, and 0 in snore.
- R7: state_lost is 1 for exactly one cycle, following the edge that starts a wake from snore, and is 0 otherwise.
- R8: activity or wake_req while ready is 0 neither extends nor restarts the wake countdown.
- R9: activity or wake_req at an edge in the active state, with ready 1, clears the idle count, so the next descent needs a full thr_l1 idle cycles again.
- R10: Idle counting restarts from zero when a wake completes. The first idle edge after ready returns to 1 counts as idle cycle one.
- R11: A synchronous active-low reset taken in any state returns pwr_sel to 00 with ready 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| activity | input | 1 | Processing block is busy this cycle |
| wake_req | input | 1 | External request to return to active |
| thr_l1 | input | CNT_W | Idle cycles to enter sleep |
| thr_l2 | input | CNT_W | Idle cycles to enter dream |
| thr_l3 | input | CNT_W | Idle cycles to enter snore |
| wake_lat_l1 | input | LAT_W | Wake cycles when leaving sleep |
| wake_lat_l2 | input | LAT_W | Wake cycles when leaving dream |
| wake_lat_l3 | input | LAT_W | Wake cycles when leaving snore |
| pwr_sel | output | 2 | Power state select |
| retain | output | 1 | Present state keeps register contents |
| ready | output | 1 | No wake sequence in progress |
| state_lost | output | 1 | One-cycle pulse on a wake from snore |

## Verification
An idle count that is off by one moves every select transition one edge early or late. Each descent is checked at the exact edge and at the edge before it, so this error shows on the first step into sleep. A wrong wake countdown shows as ready rising one cycle off the programmed latency for the level being left. A wrongly kept idle count after activity, or after a wake, shows as a premature 01 several cycles before the expected edge. A loss pulse or retention flag tied to the wrong state shows on the first wake from dream or the first entry to snore.

// File: rtl/sgov_pkg.sv
// Shared types for the sleep governor.
// Assumes the state codes are decoded directly by the power-switch control.
package sgov_pkg;
    localparam int NUM_LVL = 3;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'b00,
        PS_SLEEP  = 2'b01,
        PS_DREAM  = 2'b10,
        PS_SNORE  = 2'b11
    } pwr_state_t;
endpackage

// File: rtl/sgov_idle_counter.sv
// Saturating count of consecutive idle cycles.
// Assumes clear has priority over advance.
module sgov_idle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count idle cycles; hold at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (advance && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0); // R9
endmodule

// File: rtl/sgov_wake_timer.sv
// Wake countdown: done is high when no wake sequence is running.
// Assumes a zero load value is meant as a one-cycle wait.
module sgov_wake_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             done
);
    localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

    logic [LAT_W-1:0] remain;
    logic             past_ok;

    // Load the latency of the level being left, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (load_val == '0) ? LAT_ONE : load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Mark cycles whose history lies fully after reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    assign done = (remain == '0);

    AST_LOAD_STARTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done); // R5
    AST_COUNTDOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !load && remain != '0 |=> remain == $past(remain) - 1'b1); // R8
endmodule

// File: rtl/sgov_level_fsm.sv
// Power level selection: steps one level deeper when the next idle count
// reaches the threshold of that level and returns to active on an event.
// Assumes thresholds ascend and that run_i is low during a wake sequence.
module sgov_level_fsm
    import sgov_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LAT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic                     event_i,
    input  logic [CNT_W-1:0]         idle_cnt,
    input  logic [NUM_LVL*CNT_W-1:0] thr_pk,
    input  logic [NUM_LVL*LAT_W-1:0] lat_pk,
    output pwr_state_t               state_q,
    output logic                     wake_load,
    output logic [LAT_W-1:0]         wake_val,
    output logic                     lost_q
);
    logic [CNT_W-1:0]   thr_a [NUM_LVL];
    logic [LAT_W-1:0]   lat_a [NUM_LVL];
    logic [NUM_LVL-1:0] hit;
    logic [CNT_W:0]     idle_next;
    pwr_state_t         state_d;
    logic               lost_d;
    logic               past_ok;

    assign idle_next = {1'b0, idle_cnt} + 1'b1;

    // Unpack per-level settings and compare each threshold.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign thr_a[g] = thr_pk[g*CNT_W +: CNT_W];
        assign lat_a[g] = lat_pk[g*LAT_W +: LAT_W];
        assign hit[g]   = idle_next >= {1'b0, thr_a[g]};
    end

    // Pick the wake latency of the current low-power level.
    always_comb begin
        case (state_q)
            PS_SLEEP: wake_val = lat_a[0];
            PS_DREAM: wake_val = lat_a[1];
            PS_SNORE: wake_val = lat_a[2];
            default:  wake_val = '0;
        endcase
    end

    // Next-state decision: wake exit first, otherwise one-level descent.
    always_comb begin
        state_d   = state_q;
        wake_load = 1'b0;
        lost_d    = 1'b0;
        if (run_i) begin
            if (event_i) begin
                if (state_q != PS_ACTIVE) begin
                    state_d   = PS_ACTIVE;
                    wake_load = 1'b1;
                    lost_d    = (state_q == PS_SNORE);
                end
            end else begin
                case (state_q)
                    PS_ACTIVE: if (hit[0]) state_d = PS_SLEEP;
                    PS_SLEEP:  if (hit[1]) state_d = PS_DREAM;
                    PS_DREAM:  if (hit[2]) state_d = PS_SNORE;
                    default:   state_d = state_q;
                endcase
            end
        end
    end

    // Register the level and the loss pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ACTIVE;
            lost_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            lost_q  <= lost_d;
        end
    end

    // Mark cycles whose history lies fully after reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    AST_STEP_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && state_q != PS_ACTIVE && state_q != $past(state_q)
        |-> state_q == pwr_state_t'($past(state_q) + 2'd1)); // R3
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && event_i && state_q != PS_ACTIVE |=> state_q == PS_ACTIVE); // R4
    AST_LOST_FROM_SNORE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && lost_q |-> $past(state_q) == PS_SNORE); // R7
    AST_LOST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |=> !lost_q); // R7
    AST_RESET_ACTIVE: assert property (@(posedge clk)
        !rst_n |=> state_q == PS_ACTIVE && !lost_q); // R11
endmodule

// File: rtl/sleep_governor.sv
// Time-based sleep governor: counts idle cycles, descends through three
// low-leakage levels and runs a per-level wake countdown on any event.
// Assumes activity and wake_req are synchronous to clk.
module sleep_governor
    import sgov_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             activity,
    input  logic             wake_req,
    input  logic [CNT_W-1:0] thr_l1,
    input  logic [CNT_W-1:0] thr_l2,
    input  logic [CNT_W-1:0] thr_l3,
    input  logic [LAT_W-1:0] wake_lat_l1,
    input  logic [LAT_W-1:0] wake_lat_l2,
    input  logic [LAT_W-1:0] wake_lat_l3,
    output logic [1:0]       pwr_sel,
    output logic             retain,
    output logic             ready,
    output logic             state_lost
);
    logic             evt;
    logic [CNT_W-1:0] idle_cnt;
    logic             wake_load;
    logic [LAT_W-1:0] wake_val;
    pwr_state_t       state;

    assign evt = activity | wake_req;

    sgov_idle_counter #(.CNT_W(CNT_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (evt | ~ready),
        .advance (ready & ~evt),
        .count   (idle_cnt)
    );

    sgov_level_fsm #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ready),
        .event_i   (evt),
        .idle_cnt  (idle_cnt),
        .thr_pk    ({thr_l3, thr_l2, thr_l1}),
        .lat_pk    ({wake_lat_l3, wake_lat_l2, wake_lat_l1}),
        .state_q   (state),
        .wake_load (wake_load),
        .wake_val  (wake_val),
        .lost_q    (state_lost)
    );

    sgov_wake_timer #(.LAT_W(LAT_W)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_load),
        .load_val (wake_val),
        .done     (ready)
    );

    assign pwr_sel = state;
    assign retain  = (state != PS_SNORE);

    AST_ACTIVE_WHILE_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> pwr_sel == 2'b00); // R8
    AST_EVENT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready && evt && pwr_sel != 2'b00 |=> !ready && pwr_sel == 2'b00); // R4
endmodule

// File: tb/sleep_governor_tb.sv
`timescale 1ns/1ps
module sleep_governor_tb;
    localparam int CNT_W = 16;
    localparam int LAT_W = 8;

    typedef struct {
        int    cyc;
        int    sel;
        int    rdy;
        int    lost;
        int    ret;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             activity = 1'b0;
    logic             wake_req = 1'b0;
    logic [CNT_W-1:0] thr_l1 = 16'd4;
    logic [CNT_W-1:0] thr_l2 = 16'd10;
    logic [CNT_W-1:0] thr_l3 = 16'd20;
    logic [LAT_W-1:0] wake_lat_l1 = 8'd2;
    logic [LAT_W-1:0] wake_lat_l2 = 8'd5;
    logic [LAT_W-1:0] wake_lat_l3 = 8'd9;
    logic [1:0]       pwr_sel;
    logic             retain;
    logic             ready;
    logic             state_lost;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    sleep_governor #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .activity(activity), .wake_req(wake_req),
        .thr_l1(thr_l1), .thr_l2(thr_l2), .thr_l3(thr_l3),
        .wake_lat_l1(wake_lat_l1), .wake_lat_l2(wake_lat_l2), .wake_lat_l3(wake_lat_l3),
        .pwr_sel(pwr_sel), .retain(retain), .ready(ready), .state_lost(state_lost)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Cycle number: count of rising edges so far.
    always @(posedge clk) cyc++;

    // Compare one expected item against the ports (-1 fields are skipped).
    task automatic compare(input exp_t e);
        bit bad;
        bad = (e.sel >= 0 && int'(pwr_sel) != e.sel) ||
              (e.rdy >= 0 && int'(ready) != e.rdy) ||
              (e.lost >= 0 && int'(state_lost) != e.lost) ||
              (e.ret >= 0 && int'(retain) != e.ret);
        n_chk++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual sel=%0d rdy=%0d lost=%0d ret=%0d expected sel=%0d rdy=%0d lost=%0d ret=%0d",
                     e.tag, cyc, pwr_sel, ready, state_lost, retain, e.sel, e.rdy, e.lost, e.ret);
        end
    endtask

    // Driver side: queue an expectation for a future cycle.
    task automatic push_exp(input int at, input int sel, input int rdy,
                            input int lost, input int ret, input string tag);
        exp_t e;
        e.cyc = at; e.sel = sel; e.rdy = rdy; e.lost = lost; e.ret = ret; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: pop and check every item due at this cycle.
    always @(negedge clk) begin
        if (!done) begin
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].cyc == cyc) begin
                    compare(sb_q[i]);
                    sb_q.delete(i);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, n, m, k, j;
        exp_t e;
        repeat (3) @(negedge clk);
        e.cyc = cyc; e.sel = 0; e.rdy = 1; e.lost = 0; e.ret = 1; e.tag = "R1 reset state";
        compare(e);
        rst_n = 1'b1;
        c0 = cyc;

        // Descent through all levels (R2, R3, R6).
        push_exp(c0 + 3,  0, 1, 0, 1, "R3 before sleep");
        push_exp(c0 + 4,  1, 1, 0, 1, "R3 R2 sleep at thr_l1");
        push_exp(c0 + 9,  1, 1, 0, 1, "R3 before dream");
        push_exp(c0 + 10, 2, 1, 0, 1, "R3 R6 dream at thr_l2");
        push_exp(c0 + 19, 2, 1, 0, 1, "R3 before snore");
        push_exp(c0 + 20, 3, 1, 0, 0, "R3 R6 snore at thr_l3");
        push_exp(c0 + 26, 3, 1, 0, 0, "R3 snore holds");
        wait_to(c0 + 26);

        // Wake from snore; activity during the wake is ignored (R4 R5 R7 R8 R10).
        n = cyc;
        activity = 1'b1;
        push_exp(n + 1,  0, 0, 1, 1, "R4 R7 wake from snore");
        push_exp(n + 2,  0, 0, 0, 1, "R7 pulse is one cycle");
        push_exp(n + 9,  0, 0, 0, 1, "R5 R8 still waking");
        push_exp(n + 10, 0, 1, 0, 1, "R5 R8 snore latency ends");
        push_exp(n + 13, 0, 1, 0, 1, "R10 count restarted");
        push_exp(n + 14, 1, 1, 0, 1, "R10 sleep after full thr_l1");
        wait_to(n + 1);
        activity = 1'b0;
        wait_to(n + 3);
        activity = 1'b1;
        wait_to(n + 4);
        activity = 1'b0;
        wait_to(n + 14);

        // Wake request from sleep (R4 R5).
        m = cyc;
        wake_req = 1'b1;
        push_exp(m + 1,  0, 0, 0, 1, "R4 wake_req from sleep");
        push_exp(m + 2,  0, 0, 0, 1, "R5 sleep latency running");
        push_exp(m + 3,  0, 1, 0, 1, "R5 sleep latency ends");
        push_exp(m + 9,  0, 1, 0, 1, "R9 count cleared by activity");
        push_exp(m + 10, 1, 1, 0, 1, "R9 sleep after fresh count");
        push_exp(m + 16, 2, 1, 0, 1, "R3 dream again");
        wait_to(m + 1);
        wake_req = 1'b0;
        // Activity in active state clears the idle count (R9).
        wait_to(m + 5);
        activity = 1'b1;
        wait_to(m + 6);
        activity = 1'b0;
        wait_to(m + 16);

        // Wake from dream: no loss pulse (R5 R7).
        k = cyc;
        wake_req = 1'b1;
        wake_lat_l1 = 8'd0;
        push_exp(k + 1,  0, 0, 0, 1, "R4 R7 wake from dream no loss");
        push_exp(k + 5,  0, 0, 0, 1, "R5 dream latency running");
        push_exp(k + 6,  0, 1, 0, 1, "R5 dream latency ends");
        push_exp(k + 10, 1, 1, 0, 1, "R3 sleep again");
        wait_to(k + 1);
        wake_req = 1'b0;
        wait_to(k + 10);

        // Zero latency acts as one cycle (R5).
        j = cyc;
        activity = 1'b1;
        push_exp(j + 1,  0, 0, 0, 1, "R5 zero latency wait");
        push_exp(j + 2,  0, 1, 0, 1, "R5 zero latency one cycle");
        push_exp(j + 12, 2, 1, 0, 1, "R3 dream before reset");
        push_exp(j + 14, 0, 1, 0, 1, "R11 reset from dream");
        wait_to(j + 1);
        activity = 1'b0;
        wait_to(j + 13);
        rst_n = 1'b0;
        wait_to(j + 14);
        rst_n = 1'b1;
        wait_to(j + 16);

        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule